// File: doc/BRIEF.md
# Load/Store Address and Byte-Lane Unit

This block sits between a register file and a 32-bit byte-addressed data memory. For each access it takes a base register value and an offset, either adds or subtracts the offset, and picks the memory address: the moved address for pre-indexed accesses, or the untouched base for post-indexed ones. It also returns the moved value as the new base, with a strobe that tells the register file whether to write it back.

On the data side it steers bytes between the register and the memory word. Stores copy the low byte or halfword of the register into every lane and raise only the byte enables for the lanes the access touches. Loads pick the addressed byte or halfword out of the read word and zero-extend it. Lane placement follows a byte order chosen once at reset: little-endian puts address offset 0 in bits 7:0, and big-endian puts it in bits 31:24. All outputs are combinational in the request inputs. The only storage is the latched byte-order bit. Accesses are assumed to be naturally aligned.

Top module: `lsu_addr_lane_unit`

## Requirements
- R1: The byte order is captured from `cfg_big_endian` on every clock edge while `rst_n` is low (0 little, 1 big). Changes to that input after reset leave lane steering unchanged.
- R2: With `pre_index` high, `mem_addr` equals `base_in` plus `offset_in`, or `base_in` minus `offset_in` when `offset_sub` is high.
- R3: With `pre_index` low, `mem_addr` equals `base_in` unmodified.
- R4: `base_next` always equals `base_in` plus or minus `offset_in`, as selected by `offset_sub`, wrapping modulo 2^32.
- R5: `base_wb` is high exactly when `req_valid` is high and either `pre_index` is low or `writeback` is high.
- R6: `mem_byte_en` bit i covers data bits 8i+7:8i. It is all zero when `req_valid` is low. For `acc_size` 0 (byte) the single lane raised is the address offset in little-endian order, or 3 minus the offset in big-endian order. For `acc_size` 1 (halfword) the lanes covering offsets (a&2) and (a&2)+1 are raised under the same mapping. For 2 or 3 (word) all four lanes are raised.
- R7: `mem_wdata` holds the low byte of `store_data` repeated four times for byte size, the low halfword repeated twice for halfword size, and `store_data` unchanged for word size.
- R8: For byte size, `load_data` is the byte in the lane selected as in R6, zero-extended to 32 bits.
- R9: For halfword size, `load_data` is the 16-bit value built from offsets (a&2) and (a&2)+1, zero-extended. The lower address is the low byte in little-endian order and the high byte in big-endian order. For word size, `load_data` equals `mem_rdata`.
- R10: `mem_we` is high exactly when `req_valid` and `is_store` are both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; byte order is sampled while low |
| cfg_big_endian | input | 1 | Byte-order select, 1 = big-endian |
| req_valid | input | 1 | Access request present |
| base_in | input | 32 | Base register value |
| offset_in | input | 32 | Immediate or register offset |
| offset_sub | input | 1 | 1 = subtract offset, 0 = add |
| pre_index | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| writeback | input | 1 | Base update request for pre-indexed accesses |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| is_store | input | 1 | 1 = store, 0 = load |
| store_data | input | 32 | Register value to store |
| mem_rdata | input | 32 | Word read from memory |
| mem_addr | output | 32 | Byte address of the access |
| mem_byte_en | output | 4 | Per-lane enables |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_we | output | 1 | Write strobe |
| load_data | output | 32 | Extracted, zero-extended load value |
| base_next | output | 32 | Updated base value |
| base_wb | output | 1 | Base writeback strobe |

## Verification
The only state is the latched byte-order bit. If it were wrong or drifted, every byte and halfword access after it would show mirrored byte enables and swapped load bytes, on the very cycle the access is presented. The bench switches the configuration input after reset and confirms that lane placement does not follow it. Address, base-update and lane errors have no delay to hide behind: they appear at the ports in the same cycle as the request, so a reference model compared on every clock catches them at once.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  localparam int DW    = 32;
  localparam int LANES = DW / 8;
  localparam int OFF_W = $clog2(LANES);

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_WIDE = 2'd3
  } acc_size_e;

  // Physical lane holding a given address offset for the chosen byte order.
  function automatic logic [OFF_W-1:0] lane_of(logic [OFF_W-1:0] off, logic big);
    return big ? (OFF_W'(LANES - 1) - off) : off;
  endfunction

  function automatic logic [OFF_W-1:0] half_base(logic [OFF_W-1:0] off);
    return {off[OFF_W-1:1], 1'b0};
  endfunction

  function automatic logic [LANES-1:0] lane_mask(acc_size_e sz, logic [OFF_W-1:0] off, logic big);
    logic [LANES-1:0] m;
    m = '0;
    case (sz)
      ACC_BYTE: m[lane_of(off, big)] = 1'b1;
      ACC_HALF: begin
        m[lane_of(half_base(off), big)]        = 1'b1;
        m[lane_of(half_base(off) | 1'b1, big)] = 1'b1;
      end
      default: m = '1;
    endcase
    return m;
  endfunction

  function automatic logic [DW-1:0] replicate(acc_size_e sz, logic [DW-1:0] d);
    case (sz)
      ACC_BYTE: return {LANES{d[7:0]}};
      ACC_HALF: return {(LANES/2){d[15:0]}};
      default:  return d;
    endcase
  endfunction

  function automatic logic [7:0] pick_byte(logic [DW-1:0] w, logic [OFF_W-1:0] lane);
    return w[8*int'(lane) +: 8];
  endfunction

  function automatic logic [DW-1:0] extract(acc_size_e sz, logic [OFF_W-1:0] off, logic big,
                                           logic [DW-1:0] w);
    logic [OFF_W-1:0] lo_off, hi_off;
    lo_off = big ? (half_base(off) | 1'b1) : half_base(off);
    hi_off = big ? half_base(off) : (half_base(off) | 1'b1);
    case (sz)
      ACC_BYTE: return {{(DW-8){1'b0}}, pick_byte(w, lane_of(off, big))};
      ACC_HALF: return {{(DW-16){1'b0}}, pick_byte(w, lane_of(hi_off, big)),
                        pick_byte(w, lane_of(lo_off, big))};
      default:  return w;
    endcase
  endfunction
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [ADDR_W-1:0] offset_in,
  input  logic              offset_sub,
  input  logic              pre_index,
  input  logic              writeback,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] moved_base,
  output logic              base_wb
);
  function automatic logic [ADDR_W-1:0] step(logic [ADDR_W-1:0] b, logic [ADDR_W-1:0] o,
                                             logic neg);
    return neg ? (b - o) : (b + o);
  endfunction

  logic [ADDR_W-1:0] moved_w;
  logic              wants_wb_w;

  assign moved_w    = step(base_in, offset_in, offset_sub);
  assign wants_wb_w = ~pre_index | writeback;

  assign moved_base = moved_w;
  assign eff_addr   = pre_index ? moved_w : base_in;
  assign base_wb    = req_valid & wants_wb_w;

  assert_post_uses_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pre_index) |-> (eff_addr == base_in));
  assert_pre_uses_moved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pre_index) |-> (eff_addr == moved_base));
  assert_post_always_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !pre_index) |-> base_wb);
  assert_idle_no_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !base_wb);
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_lane_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 is_store,
  input  acc_size_e            size,
  input  logic [OFF_W-1:0]     addr_off,
  input  logic                 big_endian,
  input  logic [DW-1:0]        store_data,
  output logic [LANES-1:0]     byte_en,
  output logic [DW-1:0]        wdata,
  output logic                 we
);
  logic [LANES-1:0] mask_w;

  assign mask_w  = lane_mask(size, addr_off, big_endian);
  assign byte_en = req_valid ? mask_w : '0;
  assign wdata   = replicate(size, store_data);
  assign we      = req_valid & is_store;

  assert_byte_one_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && size == ACC_BYTE) |-> ($countones(byte_en) == 1));
  assert_half_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && size == ACC_HALF) |-> (byte_en == 4'b0011 || byte_en == 4'b1100));
  assert_idle_no_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (byte_en == '0));
  assert_byte_replicated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (size == ACC_BYTE) |-> (wdata[31:24] == store_data[7:0] && wdata[15:8] == store_data[7:0]));
  assert_we_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (req_valid && is_store));
endmodule

// File: rtl/lsu_load_lanes.sv
module lsu_load_lanes
  import lsu_lane_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  acc_size_e        size,
  input  logic [OFF_W-1:0] addr_off,
  input  logic             big_endian,
  input  logic [DW-1:0]    rdata,
  output logic [DW-1:0]    load_data
);
  assign load_data = extract(size, addr_off, big_endian, rdata);

  assert_byte_zero_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (size == ACC_BYTE) |-> (load_data[31:8] == '0));
  assert_half_zero_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (size == ACC_HALF) |-> (load_data[31:16] == '0));
  assert_word_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (size == ACC_WORD || size == ACC_WIDE) |-> (load_data == rdata));
endmodule

// File: rtl/lsu_addr_lane_unit.sv
module lsu_addr_lane_unit
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_big_endian,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [ADDR_W-1:0] offset_in,
  input  logic              offset_sub,
  input  logic              pre_index,
  input  logic              writeback,
  input  logic [1:0]        acc_size,
  input  logic              is_store,
  input  logic [DW-1:0]     store_data,
  input  logic [DW-1:0]     mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_byte_en,
  output logic [DW-1:0]     mem_wdata,
  output logic              mem_we,
  output logic [DW-1:0]     load_data,
  output logic [ADDR_W-1:0] base_next,
  output logic              base_wb
);
  logic      big_q;
  acc_size_e size_w;

  // Byte order follows the config pin only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) big_q <= cfg_big_endian;
  end

  assign size_w = acc_size_e'(acc_size);

  lsu_agen #(.ADDR_W(ADDR_W)) u_agen (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .base_in    (base_in),
    .offset_in  (offset_in),
    .offset_sub (offset_sub),
    .pre_index  (pre_index),
    .writeback  (writeback),
    .eff_addr   (mem_addr),
    .moved_base (base_next),
    .base_wb    (base_wb)
  );

  lsu_store_lanes u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .is_store   (is_store),
    .size       (size_w),
    .addr_off   (mem_addr[OFF_W-1:0]),
    .big_endian (big_q),
    .store_data (store_data),
    .byte_en    (mem_byte_en),
    .wdata      (mem_wdata),
    .we         (mem_we)
  );

  lsu_load_lanes u_load (
    .clk        (clk),
    .rst_n      (rst_n),
    .size       (size_w),
    .addr_off   (mem_addr[OFF_W-1:0]),
    .big_endian (big_q),
    .rdata      (mem_rdata),
    .load_data  (load_data)
  );

  assert_order_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(big_q));
endmodule

// File: tb/lsu_addr_lane_unit_tb_top.sv
`timescale 1ns/1ps
module lsu_addr_lane_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_big_endian = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] base_in = '0, offset_in = '0;
  logic        offset_sub = 1'b0, pre_index = 1'b0, writeback = 1'b0;
  logic [1:0]  acc_size = '0;
  logic        is_store = 1'b0;
  logic [31:0] store_data = '0;
  logic [31:0] mem_rdata;
  logic [31:0] mem_addr, mem_wdata, load_data, base_next;
  logic [3:0]  mem_byte_en;
  logic        mem_we, base_wb;

  int checks = 0;
  int errors = 0;
  bit model_big = 1'b0;
  logic [31:0] mem [16];

  always #2.5 clk = ~clk;

  lsu_addr_lane_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_big_endian(cfg_big_endian), .req_valid(req_valid),
    .base_in(base_in), .offset_in(offset_in), .offset_sub(offset_sub), .pre_index(pre_index),
    .writeback(writeback), .acc_size(acc_size), .is_store(is_store), .store_data(store_data),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_byte_en(mem_byte_en),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .load_data(load_data), .base_next(base_next),
    .base_wb(base_wb)
  );

  // Simple combinational memory, written on the clock edge.
  assign mem_rdata = mem[mem_addr[5:2]];
  always @(posedge clk) begin
    if (mem_we)
      for (int i = 0; i < 4; i++)
        if (mem_byte_en[i]) mem[mem_addr[5:2]][8*i +: 8] <= mem_wdata[8*i +: 8];
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pos(int j);
    return model_big ? 3 - j : j;
  endfunction

  // Reference model: compare every output in the current cycle.
  task automatic compare();
    logic [31:0] sum, ea, exp_wd, exp_ld;
    logic [3:0]  exp_be;
    int first, n;
    sum = offset_sub ? base_in - offset_in : base_in + offset_in;
    ea  = pre_index ? sum : base_in;
    if (acc_size == 2'd0) begin first = int'(ea[1:0]); n = 1; end
    else if (acc_size == 2'd1) begin first = int'(ea[1:0]) & 2; n = 2; end
    else begin first = 0; n = 4; end
    exp_be = '0;
    exp_ld = '0;
    for (int j = 0; j < n; j++) begin
      exp_be[pos(first + j)] = 1'b1;
      if (model_big) exp_ld = (exp_ld << 8) | 32'(mem_rdata[8*pos(first + j) +: 8]);
      else           exp_ld = exp_ld | (32'(mem_rdata[8*pos(first + j) +: 8]) << (8*j));
    end
    if (!req_valid) exp_be = '0;
    case (acc_size)
      2'd0:    exp_wd = {4{store_data[7:0]}};
      2'd1:    exp_wd = {2{store_data[15:0]}};
      default: exp_wd = store_data;
    endcase
    check(pre_index ? "R2 addr" : "R3 addr", mem_addr, ea);
    check("R4 base_next", base_next, sum);
    check("R5 base_wb", 32'(base_wb), 32'(req_valid & (~pre_index | writeback)));
    check("R6 byte_en (R1 order)", 32'(mem_byte_en), 32'(exp_be));
    check("R7 wdata", mem_wdata, exp_wd);
    check(acc_size == 2'd0 ? "R8 load" : "R9 load", load_data, exp_ld);
    check("R10 we", 32'(mem_we), 32'(req_valid & is_store));
  endtask

  task automatic drive(logic v, logic [31:0] b, logic [31:0] o, logic sb, logic pr,
                       logic wb, logic [1:0] sz, logic st, logic [31:0] d);
    @(posedge clk); #1;
    req_valid = v; base_in = b; offset_in = o; offset_sub = sb; pre_index = pr;
    writeback = wb; acc_size = sz; is_store = st; store_data = d;
    @(negedge clk);
    compare();
  endtask

  task automatic random_run(int cnt);
    for (int k = 0; k < cnt; k++)
      drive(($urandom % 8) != 0, $urandom % 64, ($urandom % 2) ? $urandom % 16 : $urandom,
            $urandom % 2, $urandom % 2, $urandom % 2, 2'($urandom % 4), $urandom % 2, $urandom);
  endtask

  task automatic do_reset(bit big);
    @(posedge clk); #1;
    rst_n = 1'b0; req_valid = 1'b0; cfg_big_endian = big;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: idle outputs quiet (R5, R6, R10)
    check("R6 reset byte_en", 32'(mem_byte_en), 32'h0);
    check("R5 reset base_wb", 32'(base_wb), 32'h0);
    check("R10 reset we", 32'(mem_we), 32'h0);
    model_big = big;
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h11223344 + 32'(i) * 32'h01010101;
    do_reset(1'b0);
    // little-endian directed lanes: byte at offset 1 -> lane 1 (R6, R8)
    drive(1, 32'h21, 0, 0, 1, 0, 2'd0, 0, 0);
    drive(1, 32'h12, 0, 0, 0, 0, 2'd1, 0, 0);               // R9 upper half, post-index R3
    drive(1, 32'h0, 32'h4, 1, 1, 1, 2'd2, 1, 32'hCAFEF00D); // R4 wrap to FFFFFFFC
    drive(1, 32'h10, 32'h3, 0, 1, 0, 2'd0, 1, 32'h000000AB); // R7 byte store
    drive(1, 32'h13, 0, 0, 1, 0, 2'd0, 0, 0);               // load back stored byte
    random_run(300);
    // R1: config changes after reset must not move lanes
    cfg_big_endian = 1'b1;
    random_run(100);
    do_reset(1'b1);
    drive(1, 32'h21, 0, 0, 1, 0, 2'd0, 0, 0);               // big-endian byte: lane 2
    drive(1, 32'h12, 0, 0, 1, 0, 2'd1, 0, 0);               // R9 big-endian half
    drive(1, 32'h14, 32'h4, 1, 1, 0, 2'd1, 1, 32'h0000BEEF); // R2 subtract, halfword store
    drive(1, 32'h10, 0, 0, 1, 0, 2'd1, 0, 0);
    cfg_big_endian = 1'b0;
    random_run(300);
    drive(0, 32'h8, 32'h4, 0, 0, 1, 2'd0, 1, 0);            // idle: no enables, no wb
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule